// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block is an up-counting timer with a single edge-aligned pulse-width output. A counter runs from zero to a programmable modulo value and then wraps to zero. One wrap ends one PWM period. The channel output takes one level from the wrap until the counter reaches a programmable compare value, and the opposite level from there to the end of the period. A two-bit select input chooses which level comes first, or turns the channel off.

Two sticky flags report timer events. The first marks each wrap. The second marks each compare hit. Software clears each flag with its own one-cycle clear strobe.

Software may write the modulo and compare inputs at any time. The timer copies them into its working registers only when the counter wraps, so a running period is never shortened or stretched. Two compare values force a constant level for the whole period, and neither raises the compare flag:

- A compare value of zero holds the output at its post-compare level.
- A compare value above the modulo holds the output at its post-wrap level.

Top module: `epwm_channel`

## Requirements
- R1: The counter steps by one on each clock from 0 up to the active modulo value M, then returns to 0 on the next clock, so one period lasts M+1 cycles.
- R2: The wrap flag is set on the clock edge where the counter goes from M to 0. It then holds until a cycle with the wrap clear strobe high. A wrap in the same cycle as the clear leaves the flag set.
- R3: With select = 2'b10, the output is high from the wrap until the count reaches the active compare value C, and low from there to the end of the period. It is therefore high for C of the M+1 cycles.
- R4: With select bit 0 = 1, the output is low from the wrap and high from the count where it reaches C. Select bit 1 has no effect in this case.
- R5: With C = 0, the output stays at its post-compare level for the whole period, and the compare flag is not set. With M = 2^CW-1, no C exceeds M, so a constant post-wrap level cannot be reached.
- R6: With C > M, the output stays at its post-wrap level for the whole period, and the compare flag is not set.
- R7: The compare flag is set on the edge where the counter becomes C, provided 1 <= C <= M. It then holds until a cycle with the compare clear strobe high. A hit in the same cycle as the clear leaves the flag set.
- R8: Modulo and compare inputs are copied into the active values only on a wrap edge. Changes made mid-period do not affect the running period.
- R9: With select = 2'b00, the output is held low. Counting and both flags carry on as usual.
- R10: While reset is asserted, the following hold:
  - the counter, the active modulo and the active compare are zero;
  - both flags are clear;
  - the output sits at the post-wrap level of the present select.
  
  The first clock after release is therefore a wrap. That wrap sets the wrap flag and loads the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_i | input | CW | Modulo value written by software; loaded at wrap |
| cmp_i | input | CW | Compare value written by software; loaded at wrap |
| sel_i | input | 2 | Level select: 00 off, 10 high first, x1 low first |
| ovf_clr_i | input | 1 | Clear strobe for the wrap flag |
| match_clr_i | input | 1 | Clear strobe for the compare flag |
| pwm_o | output | 1 | Channel output |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| match_flag_o | output | 1 | Sticky compare flag |

## Verification
The bench builds the block with CW = 8. At that width a full-range period of 256 cycles is short enough to measure completely. Both ends of the duty range can then be run:

- M = 254 with C = 255, which gives a constant level;
- M = 255 with C = 255, where the constant level is unreachable and one low cycle remains.

The small width also makes the degenerate M = 0 period, which wraps on every clock, cheap to exercise, alongside the other mid-range patterns and the deferred-update case.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

  typedef enum logic {
    PH_CMP = 1'b0,
    PH_OVF = 1'b1
  } phase_e;

  function automatic logic chan_on(input logic [1:0] sel);
    return |sel;
  endfunction

  // Level driven from the wrap until the compare hit.
  function automatic logic wrap_level(input logic [1:0] sel);
    return ~sel[0];
  endfunction

endpackage

// File: rtl/epwm_counter.sv
module epwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] mod_i,
  input  logic [CW-1:0] cmp_i,
  output logic          wrap_o,
  output logic [CW-1:0] cnt_d_o,
  output logic [CW-1:0] mod_d_o,
  output logic [CW-1:0] cmp_d_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] mod_q, mod_d;
  logic [CW-1:0] cmp_q, cmp_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == mod_q);
    cnt_d = wrap ? '0 : cnt_q + ONE;
    mod_d = wrap ? mod_i : mod_q;
    cmp_d = wrap ? cmp_i : cmp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Working registers are only written on a wrap.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= '0;
      cmp_q <= '0;
    end else if (wrap) begin
      mod_q <= mod_d;
      cmp_q <= cmp_d;
    end
  end

  assign wrap_o  = wrap;
  assign cnt_d_o = cnt_d;
  assign mod_d_o = mod_d;
  assign cmp_d_o = cmp_d;

  // R1: wrap returns the count to zero
  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == mod_q) |=> (cnt_q == '0));

  // R1: otherwise the count steps by one
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != mod_q) |=> (cnt_q == $past(cnt_q) + ONE));

  // R8: configuration held inside a period
  a_r8_hold_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != mod_q) |=> ($stable(mod_q) && $stable(cmp_q)));

  // R1: count never exceeds active modulo
  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= mod_q));

endmodule

// File: rtl/epwm_sticky.sv
module epwm_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  // A set in the same cycle as a clear wins.
  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R2 / R7: set wins over clear
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

  // R2 / R7: flag holds without set or clear
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_q));

endmodule

// File: rtl/epwm_outgen.sv
module epwm_outgen
  import epwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_d_i,
  input  logic [CW-1:0] mod_d_i,
  input  logic [CW-1:0] cmp_d_i,
  input  logic [1:0]    sel_i,
  output logic          hit_o,
  output logic          pwm_o
);

  phase_e phase_q, phase_d;
  logic   cmp_valid;

  // Phase of the count the counter moves to on this edge.
  always_comb begin
    cmp_valid = (cmp_d_i != '0) && (cmp_d_i <= mod_d_i);
    hit_o     = cmp_valid && (cnt_d_i == cmp_d_i);
    phase_d   = (cnt_d_i < cmp_d_i) ? PH_OVF : PH_CMP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OVF;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_comb begin
    if (!chan_on(sel_i)) begin
      pwm_o = 1'b0;
    end else if (phase_q == PH_OVF) begin
      pwm_o = wrap_level(sel_i);
    end else begin
      pwm_o = ~wrap_level(sel_i);
    end
  end

  // R6: compare above modulo keeps the post-wrap phase
  a_r6_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_d_i > mod_d_i) |=> (phase_q == PH_OVF));

  // R5: zero compare keeps the post-compare phase
  a_r5_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_d_i == '0) |=> (phase_q == PH_CMP));

  // R5 / R6: no hit for out-of-range compare
  a_r5_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmp_d_i == '0) || (cmp_d_i > mod_d_i)) |-> !hit_o);

endmodule

// File: rtl/epwm_channel.sv
module epwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] mod_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [1:0]    sel_i,
  input  logic          ovf_clr_i,
  input  logic          match_clr_i,
  output logic          pwm_o,
  output logic          ovf_flag_o,
  output logic          match_flag_o
);

  localparam int NFLAG = 2;

  logic          wrap;
  logic          hit;
  logic [CW-1:0] cnt_d, mod_d, cmp_d;

  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  epwm_counter #(.CW(CW)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mod_i   (mod_i),
    .cmp_i   (cmp_i),
    .wrap_o  (wrap),
    .cnt_d_o (cnt_d),
    .mod_d_o (mod_d),
    .cmp_d_o (cmp_d)
  );

  epwm_outgen #(.CW(CW)) u_outgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_d_i (cnt_d),
    .mod_d_i (mod_d),
    .cmp_d_i (cmp_d),
    .sel_i   (sel_i),
    .hit_o   (hit),
    .pwm_o   (pwm_o)
  );

  // Flag 0: wrap, flag 1: compare hit.
  assign flag_set = {hit, wrap};
  assign flag_clr = {match_clr_i, ovf_clr_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    epwm_sticky u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flag_q[g])
    );
  end

  assign ovf_flag_o   = flag_q[0];
  assign match_flag_o = flag_q[1];

  // R9: disabled channel stays low across edges
  a_r9_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b00) |-> !pwm_o);

  // R5: zero compare never raises the compare flag
  a_r5_zero_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmp_d == '0) && !match_flag_o) |=> !match_flag_o);

endmodule

// File: tb/test_epwm_channel.sv
`timescale 1ns/1ps
module test_epwm_channel;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] mod_i, cmp_i;
  logic [1:0]    sel_i;
  logic          ovf_clr, match_clr;
  logic          pwm, ovf_flag, match_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  epwm_channel #(.CW(CW)) i_epwm_channel (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mod_i        (mod_i),
    .cmp_i        (cmp_i),
    .sel_i        (sel_i),
    .ovf_clr_i    (ovf_clr),
    .match_clr_i  (match_clr),
    .pwm_o        (pwm),
    .ovf_flag_o   (ovf_flag),
    .match_flag_o (match_flag)
  );

  typedef struct packed {
    logic [7:0]  m;
    logic [7:0]  c;
    logic [1:0]  s;
    logic [15:0] hi;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'd8,   8'd5,   2'b10, 16'd5,   1'b1, 4'd3},  // R3
    '{8'd8,   8'd5,   2'b01, 16'd4,   1'b1, 4'd4},  // R4
    '{8'd8,   8'd5,   2'b11, 16'd4,   1'b1, 4'd4},  // R4 upper bit ignored
    '{8'd8,   8'd0,   2'b10, 16'd0,   1'b0, 4'd5},  // R5
    '{8'd8,   8'd0,   2'b01, 16'd9,   1'b0, 4'd5},  // R5
    '{8'd8,   8'd9,   2'b10, 16'd9,   1'b0, 4'd6},  // R6
    '{8'd8,   8'd200, 2'b01, 16'd0,   1'b0, 4'd6},  // R6
    '{8'd3,   8'd1,   2'b10, 16'd1,   1'b1, 4'd7},  // R7 hit coincides with clear
    '{8'd3,   8'd3,   2'b10, 16'd3,   1'b1, 4'd7},  // R7 compare at modulo
    '{8'd8,   8'd5,   2'b00, 16'd0,   1'b1, 4'd9},  // R9
    '{8'd254, 8'd255, 2'b10, 16'd255, 1'b0, 4'd6},  // R6 largest 100% case
    '{8'd255, 8'd255, 2'b10, 16'd255, 1'b1, 4'd5},  // R5 full modulo, no 100%
    '{8'd0,   8'd1,   2'b10, 16'd1,   1'b0, 4'd1},  // R1 single-cycle period
    '{8'd0,   8'd0,   2'b10, 16'd0,   1'b0, 4'd1}   // R1
  };

  task automatic check(input logic ok, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Clear the wrap flag, then wait for the next wrap (sampled on negedge).
  task automatic wait_wrap();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    while (!ovf_flag) @(negedge clk);
  endtask

  // Called at the negedge just after a wrap; ends at the next one.
  task automatic measure(input int m, input int exp_hi, input logic exp_hit,
                         input int req);
    int hi = 0;
    hi += int'(pwm);
    ovf_clr   = 1'b1;
    match_clr = 1'b1;
    @(negedge clk);
    ovf_clr   = 1'b0;
    match_clr = 1'b0;
    if (m == 0) begin
      check(ovf_flag == 1'b1, 2, "wrap flag set wins over clear", int'(ovf_flag), 1);
      check(match_flag == exp_hit, 7, "compare flag", int'(match_flag), int'(exp_hit));
    end else begin
      hi += int'(pwm);
      for (int k = 2; k <= m; k++) begin
        @(negedge clk);
        hi += int'(pwm);
      end
      check(ovf_flag == 1'b0, 1, "no wrap before period end", int'(ovf_flag), 0);
      check(match_flag == exp_hit, req, "compare flag", int'(match_flag), int'(exp_hit));
      @(negedge clk);
      check(ovf_flag == 1'b1, 2, "wrap flag after M+1 cycles", int'(ovf_flag), 1);
    end
    check(hi == exp_hi, req, "high cycles per period", hi, exp_hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    mod_i     = 8'd8;
    cmp_i     = 8'd5;
    sel_i     = 2'b10;
    ovf_clr   = 1'b0;
    match_clr = 1'b0;
    #12;
    // R10: reset state
    check(pwm == 1'b1, 10, "reset output high-first", int'(pwm), 1);
    check(ovf_flag == 1'b0, 10, "reset wrap flag", int'(ovf_flag), 0);
    check(match_flag == 1'b0, 10, "reset compare flag", int'(match_flag), 0);
    sel_i = 2'b01;
    #1;
    check(pwm == 1'b0, 10, "reset output low-first", int'(pwm), 0);
    sel_i = 2'b10;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: first edge after release is a wrap that loads the inputs
    check(ovf_flag == 1'b1, 10, "first edge wraps", int'(ovf_flag), 1);
    check(pwm == 1'b1, 10, "output after first wrap", int'(pwm), 1);
    measure(8, 5, 1'b1, 10);

    for (int i = 0; i < NV; i++) begin
      mod_i = VECS[i].m;
      cmp_i = VECS[i].c;
      sel_i = VECS[i].s;
      wait_wrap();
      measure(int'(VECS[i].m), int'(VECS[i].hi), VECS[i].hit, int'(VECS[i].req));
    end

    // R8: mid-period writes wait for the next wrap
    mod_i = 8'd8;
    cmp_i = 8'd5;
    sel_i = 2'b10;
    wait_wrap();
    mod_i = 8'd3;
    cmp_i = 8'd1;
    measure(8, 5, 1'b1, 8);
    measure(3, 1, 1'b1, 8);

    // R9: disabled output stays low while flags keep working
    sel_i = 2'b00;
    @(negedge clk);
    check(pwm == 1'b0, 9, "disabled output", int'(pwm), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule